// File: doc/BRIEF.md
# Synchronous Channel Unmute Sequencer

This block brings synchronous streaming channels out of mute once the serial bus has come up. Every channel is described by a 3-bit type code. A channel whose code marks it as synchronous is held muted, and channels of every other type are never muted. A start command launches a fixed sequence. The block first confirms that the bus clock is present. Next it waits for link lock. It then lets four frames pass while lock holds, and only after that does it release mute on the synchronous channels.

If the clock-missing status flag is set when the block checks it, the block pulses a clear output for one cycle. It then idles for one cycle and checks the flag again. If lock drops during the frame settle window, the sequence goes back to the clock check and the channels stay muted. When the sequence finishes, a done flag rises and stays high until the next start command.

Top module: `sync_unmute_seq`

## Requirements
- R1: A channel whose type code is 000 (synchronous) has its mute output high whenever done_o is low. Channels with any other code (001 control, 010 asynchronous, 011 isochronous, or an unused code) always have mute low.
- R2: A start command sampled at a clock edge moves the block to the clock check. At the next edge the block samples clk_missing_i. If the flag is 1, clr_missing_o is high for exactly the one following cycle.
- R3: After a clear pulse, the block spends one cycle idle and then samples clk_missing_i again. While the flag stays 1, this repeats with a 3-cycle period.
- R4: Once clk_missing_i has been sampled as 0, the block waits for lock_i = 1 for as long as needed. During that wait done_o stays low and frame strobes are not counted.
- R5: Counting begins at the edge where lock_i is first sampled as 1, and a strobe at that same edge is not counted. done_o rises the cycle after the fourth frame strobe that is sampled while lock_i is 1.
- R6: If lock_i is sampled as 0 during the settle window, the block returns to the clock check, discards the frames counted so far, and keeps the channels muted.
- R7: After done_o rises, it stays high and every mute output stays low until a start command. The start command drops done_o and mutes the synchronous channels again in the next cycle.
- R8: A start command sampled in any phase of the sequence restarts it from the clock check.
- R9: In reset and before any start command, done_o and clr_missing_o are low and the synchronous channels are muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command, sampled each edge |
| clk_missing_i | input | 1 | Bus clock missing status flag |
| lock_i | input | 1 | Link lock status flag |
| frame_i | input | 1 | Single-cycle frame sync strobe |
| ch_type_i | input | NUM_CH*3 | Per-channel type codes, channel i at bits [3i+2:3i] |
| clr_missing_o | output | 1 | One-cycle pulse that clears the clock-missing flag |
| mute_o | output | NUM_CH | Per-channel mute |
| done_o | output | 1 | Sequence complete, mute released |

## Verification
The assertions assume that frame_i, lock_i and clk_missing_i are synchronous to clk. They also assume that the clock-missing flag settles during the idle cycle after a clear pulse, so that each recheck sees a meaningful value. The stimulus drives every input half a cycle away from the sampling edge. It holds the flag high for a bounded number of checks and then releases it, and it raises and drops lock only at chosen points: before the lock wait, inside the settle window, and together with a frame strobe.

// File: rtl/usq_pkg.sv
package usq_pkg;
   localparam int TYPE_W = 3;
   localparam logic [TYPE_W-1:0] CT_SYNC  = 3'b000;
   localparam logic [TYPE_W-1:0] CT_CTRL  = 3'b001;
   localparam logic [TYPE_W-1:0] CT_ASYNC = 3'b010;
   localparam logic [TYPE_W-1:0] CT_ISOC  = 3'b011;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CHECK,
      PH_CLEAR,
      PH_GAP,
      PH_LOCK,
      PH_SETTLE,
      PH_DONE
   } usq_phase_e;

   function automatic logic type_is_sync(input logic [TYPE_W-1:0] code);
      return code == CT_SYNC;
   endfunction
endpackage

// File: rtl/usq_frame_counter.sv
module usq_frame_counter #(
   parameter int FRAMES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic count_i,
   output logic last_o
);
   localparam int CW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
   localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

   generate
      if (FRAMES == 1) begin : g_single
         assign last_o = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (clear_i) cnt_q <= '0;
            else if (count_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         end
         assign last_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/usq_mute_decode.sv
module usq_mute_decode
   import usq_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic [NUM_CH*TYPE_W-1:0] ch_type_i,
   input  logic                     release_i,
   output logic [NUM_CH-1:0]        mute_o
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         assign mute_o[gi] = type_is_sync(ch_type_i[gi*TYPE_W +: TYPE_W]) && !release_i;
      end
   endgenerate
endmodule

// File: rtl/usq_ctrl.sv
module usq_ctrl
   import usq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic clk_missing_i,
   input  logic lock_i,
   input  logic frame_i,
   input  logic frames_last_i,
   output logic cnt_clear_o,
   output logic cnt_step_o,
   output logic clr_missing_o,
   output logic done_o
);
   usq_phase_e ph_q, ph_d;

   always_comb begin
      ph_d = ph_q;
      if (start_i) begin
         ph_d = PH_CHECK;
      end else begin
         case (ph_q)
            PH_IDLE:   ph_d = PH_IDLE;
            PH_CHECK:  ph_d = clk_missing_i ? PH_CLEAR : PH_LOCK;
            PH_CLEAR:  ph_d = PH_GAP;
            PH_GAP:    ph_d = PH_CHECK;
            PH_LOCK:   ph_d = lock_i ? PH_SETTLE : PH_LOCK;
            PH_SETTLE: begin
               if (!lock_i)                      ph_d = PH_CHECK;
               else if (frame_i && frames_last_i) ph_d = PH_DONE;
            end
            PH_DONE:   ph_d = PH_DONE;
            default:   ph_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign cnt_clear_o   = (ph_q != PH_SETTLE) || start_i || !lock_i;
   assign cnt_step_o    = (ph_q == PH_SETTLE) && lock_i && frame_i;
   assign clr_missing_o = (ph_q == PH_CLEAR);
   assign done_o        = (ph_q == PH_DONE);
endmodule

// File: rtl/sync_unmute_seq.sv
module sync_unmute_seq
   import usq_pkg::*;
#(
   parameter int NUM_CH        = 8,
   parameter int SETTLE_FRAMES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     clk_missing_i,
   input  logic                     lock_i,
   input  logic                     frame_i,
   input  logic [NUM_CH*TYPE_W-1:0] ch_type_i,
   output logic                     clr_missing_o,
   output logic [NUM_CH-1:0]        mute_o,
   output logic                     done_o
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("sync_unmute_seq: NUM_CH must be at least 1");
      end
      if (SETTLE_FRAMES < 1) begin : g_bad_frames
         $error("sync_unmute_seq: SETTLE_FRAMES must be at least 1");
      end
   endgenerate

   logic cnt_clear, cnt_step, frames_last;

   usq_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .clk_missing_i (clk_missing_i),
      .lock_i        (lock_i),
      .frame_i       (frame_i),
      .frames_last_i (frames_last),
      .cnt_clear_o   (cnt_clear),
      .cnt_step_o    (cnt_step),
      .clr_missing_o (clr_missing_o),
      .done_o        (done_o)
   );

   usq_frame_counter #(.FRAMES(SETTLE_FRAMES)) u_frames (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (cnt_clear),
      .count_i (cnt_step),
      .last_o  (frames_last)
   );

   usq_mute_decode #(.NUM_CH(NUM_CH)) u_mute (
      .ch_type_i (ch_type_i),
      .release_i (done_o),
      .mute_o    (mute_o)
   );
endmodule

// File: rtl/usq_checker.sv
module usq_checker
   import usq_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start_i,
   input logic                     clk_missing_i,
   input logic                     lock_i,
   input logic                     frame_i,
   input logic [NUM_CH*TYPE_W-1:0] ch_type_i,
   input logic                     clr_missing_o,
   input logic [NUM_CH-1:0]        mute_o,
   input logic                     done_o
);
   logic [NUM_CH-1:0] sync_mask;
   always_comb begin
      for (int i = 0; i < NUM_CH; i++)
         sync_mask[i] = (ch_type_i[i*TYPE_W +: TYPE_W] == 3'b000);
   end

   AST_NONSYNC_UNMUTED: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_o & ~sync_mask) == '0); // R1
   AST_SYNC_MUTED_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> mute_o == sync_mask); // R1
   AST_CLEAR_NEEDS_MISSING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clr_missing_o) |-> $past(clk_missing_i) && !$past(start_i)); // R2
   AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_missing_o |=> !clr_missing_o); // R3
   AST_DONE_NEEDS_LOCK_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(lock_i) && $past(frame_i)); // R5
   AST_DONE_UNMUTES: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> mute_o == '0); // R7
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> done_o); // R7
   AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !done_o && !clr_missing_o); // R8
   AST_EXCLUSIVE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && clr_missing_o)); // R9
endmodule

bind sync_unmute_seq usq_checker #(.NUM_CH(NUM_CH)) u_usq_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .clk_missing_i (clk_missing_i),
   .lock_i        (lock_i),
   .frame_i       (frame_i),
   .ch_type_i     (ch_type_i),
   .clr_missing_o (clr_missing_o),
   .mute_o        (mute_o),
   .done_o        (done_o)
);

// File: tb/sync_unmute_seq_test.sv
`timescale 1ns/1ps
module sync_unmute_seq_test;
   localparam int NCH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, clk_missing_i = 1'b0, lock_i = 1'b0, frame_i = 1'b0;
   logic [NCH*3-1:0] ch_type_i;
   logic clr_missing_o, done_o;
   logic [NCH-1:0] mute_o;

   always #4 clk = ~clk;

   sync_unmute_seq #(.NUM_CH(NCH), .SETTLE_FRAMES(4)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .clk_missing_i(clk_missing_i),
      .lock_i(lock_i), .frame_i(frame_i), .ch_type_i(ch_type_i),
      .clr_missing_o(clr_missing_o), .mute_o(mute_o), .done_o(done_o));

   int vectors = 0;
   int miscompares = 0;
   // reference model: 0 idle, 1 check, 2 clear, 3 gap, 4 lock wait, 5 settle, 6 done
   int m_phase = 0;
   int m_frames = 0;
   string tag = "R9";

   function automatic logic [NCH-1:0] sync_of(input logic [NCH*3-1:0] t);
      logic [NCH-1:0] r;
      for (int i = 0; i < NCH; i++) r[i] = (t[i*3 +: 3] == 3'd0);
      return r;
   endfunction

   task automatic compare();
      logic [NCH-1:0] exp_mute;
      logic exp_done, exp_clr;
      exp_done = (m_phase == 6);
      exp_clr  = (m_phase == 2);
      exp_mute = exp_done ? '0 : sync_of(ch_type_i);
      vectors += 3;
      if (done_o !== exp_done) begin
         miscompares++;
         $display("FAIL %s done_o=%b expected %b t=%0t", tag, done_o, exp_done, $time);
      end
      if (clr_missing_o !== exp_clr) begin
         miscompares++;
         $display("FAIL %s clr_missing_o=%b expected %b t=%0t", tag, clr_missing_o, exp_clr, $time);
      end
      if (mute_o !== exp_mute) begin
         miscompares++;
         $display("FAIL R1 (%s) mute_o=%b expected %b t=%0t", tag, mute_o, exp_mute, $time);
      end
   endtask

   task automatic model_step();
      if (!rst_n) begin
         m_phase = 0;
         m_frames = 0;
      end else if (start_i) begin
         m_phase = 1;
         m_frames = 0;
      end else begin
         case (m_phase)
            1: m_phase = clk_missing_i ? 2 : 4;
            2: m_phase = 3;
            3: m_phase = 1;
            4: if (lock_i) begin m_phase = 5; m_frames = 0; end
            5: begin
               if (!lock_i) m_phase = 1;
               else if (frame_i) begin
                  m_frames++;
                  if (m_frames == 4) m_phase = 6;
               end
            end
            default: ;
         endcase
      end
   endtask

   // one clock: compare the state after the last edge, drive inputs, advance model
   task automatic cyc(input logic st, input logic miss, input logic lk, input logic fr, input string t);
      @(negedge clk);
      compare();
      tag = t;
      start_i = st; clk_missing_i = miss; lock_i = lk; frame_i = fr;
      model_step();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      miscompares++;
      $display("FAIL watchdog expired, expected completion");
      finish_run();
   end

   initial begin
      // ch0 sync, ch1 ctrl, ch2 async, ch3 isoc, ch4 sync, ch5 isoc, ch6 sync, ch7 unused code
      ch_type_i = {3'd5, 3'd0, 3'd3, 3'd0, 3'd3, 3'd2, 3'd1, 3'd0};
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R9");
      rst_n = 1'b1;
      // idle: lock and frames without start change nothing
      for (int i = 0; i < 6; i++) cyc(0, 0, 1, i[0], "R9");
      // R2 R3: start with clock missing for three checks
      cyc(1, 1, 0, 0, "R8");
      for (int i = 0; i < 9; i++) cyc(0, 1, 0, 0, "R3");
      // release missing, then wait long for lock with frames (R4)
      for (int i = 0; i < 12; i++) cyc(0, 0, 0, (i % 3) == 0, "R4");
      // R5: lock with a frame in the same cycle, which must not count
      cyc(0, 0, 1, 1, "R5");
      for (int i = 0; i < 14; i++) cyc(0, 0, 1, (i % 3) == 1, "R5");
      // R7: done holds while lock, frames, missing and types move
      for (int i = 0; i < 5; i++) cyc(0, i[0], i[1], 1, "R7");
      ch_type_i[1*3 +: 3] = 3'd0;
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R7");
      // R7 R8: start re-mutes, then lock drop inside settle (R6)
      cyc(1, 0, 1, 0, "R7");
      cyc(0, 0, 1, 0, "R6");
      for (int i = 0; i < 6; i++) cyc(0, 0, 1, i[0], "R6");
      cyc(0, 0, 0, 1, "R6");
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R6");
      for (int i = 0; i < 12; i++) cyc(0, 0, 1, 1, "R6");
      // R8: start during settle restarts; missing appears on recheck
      cyc(1, 0, 1, 0, "R8");
      cyc(0, 0, 1, 0, "R8");
      cyc(0, 0, 1, 1, "R8");
      cyc(0, 0, 1, 1, "R8");
      cyc(1, 1, 1, 1, "R8");
      for (int i = 0; i < 4; i++) cyc(0, i < 2, 1, 1, "R2");
      for (int i = 0; i < 10; i++) cyc(0, 0, 1, 1, "R5");
      ch_type_i = {3'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd4, 3'd0};
      cyc(1, 0, 0, 0, "R1");
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R1");
      cyc(0, 0, 0, 0, "R1");
      finish_run();
   end
endmodule